// File: doc/BRIEF.md
# Differentiating Spare ALU Cell

This block is a dormant spare cell that sits among four working cells and can take over the job of any one of them once that neighbour has been retired. While dormant it produces nothing: its result port reads zero and its valid flag stays low, whatever the neighbours present on their ports. A differentiation request, together with a two-bit direction code, tells it which neighbour to stand in for. On the first clock edge that sees the request, the cell stores the direction and becomes a working cell. In the cycle that follows it sends a one-cycle clear pulse so the external request bit can be dropped.

Once differentiated, the cell takes opcode, operands and the valid flag from the port of the neighbour it replaced and runs them through a small ALU with four operations: add, subtract, multiply and shift left. The result is registered. Further requests or changes to the direction code have no effect until the next reset. After a reset the cell is dormant again and can be differentiated toward a new neighbour, so it can serve a later fault.

Top module: `spare_alu_cell`

## Requirements
- R1: While the cell is dormant, `active_o`, `diff_clr_o` and `res_valid_o` are low and `res_o` is zero, regardless of activity on any neighbour port.
- R2: When `diff_req_i` is high at a rising edge while dormant, the cell stores `dir_i` and `active_o` is high from that edge on. Direction codes select neighbour ports: 2'b00 up (port 0), 2'b01 down (port 1), 2'b10 right (port 2), 2'b11 left (port 3).
- R3: `diff_clr_o` is high for exactly the one cycle after the accepting edge, and it is never high at any other time.
- R4: Opcode 2'b00 gives A+B including the carry in bit DATA_W. 2'b01 gives (A-B) mod 2^DATA_W with the upper half zero. 2'b10 gives the full 2*DATA_W product. 2'b11 gives A zero-extended to 2*DATA_W and shifted left by the low log2(DATA_W) bits of B.
- R5: When the cell is differentiated and the selected port has its valid bit high at an edge, `res_valid_o` is high and `res_o` holds that port's result in the following cycle. This also applies on consecutive cycles.
- R6: When the cell is differentiated and the selected port's valid bit is low, `res_valid_o` is low in the next cycle and `res_o` keeps its previous value. Valid inputs on the other ports have no effect.
- R7: After differentiation, later values of `dir_i` and `diff_req_i` neither change the neighbour that is used nor produce another clear pulse.
- R8: Reset returns the cell to the dormant state. After reset it can be differentiated toward any of the four directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| diff_req_i | input | 1 | Differentiation request bit |
| dir_i | input | 2 | Direction code of the neighbour to replace |
| diff_clr_o | output | 1 | One-cycle pulse clearing the request bit |
| active_o | output | 1 | Cell has differentiated |
| nb_valid_i | input | 4 | Per-neighbour input valid, bit k is port k |
| nb_op_i | input | 8 | Per-neighbour opcode, bits [2k+1:2k] for port k |
| nb_a_i | input | 4*DATA_W | Per-neighbour operand A, slice k is port k |
| nb_b_i | input | 4*DATA_W | Per-neighbour operand B, slice k is port k |
| res_valid_o | output | 1 | Registered result valid |
| res_o | output | 2*DATA_W | Registered result |

## Verification
The assertions assume that `diff_req_i`, `dir_i` and every neighbour input are synchronous to `clk`. They also assume that the request is not meaningful during the two cycles in which the internal reset is still held after `rst_n` rises. Under these assumptions the clear pulse, the sticky active state and the one-cycle result latency can be checked edge to edge against the latched direction. The stimulus changes all inputs on the falling edge only. It waits three cycles after every reset release before it raises a request. The ports that are not selected are loaded with valid traffic whose results differ from every expected value, so that taking a result from the wrong neighbour is always visible.

// File: rtl/spare_cell_pkg.sv
package spare_cell_pkg;

  localparam int unsigned NB_N  = 4;
  localparam int unsigned DIR_W = 2;
  localparam int unsigned OP_W  = 2;

  typedef enum logic [DIR_W-1:0] {
    DIR_UP    = 2'b00,
    DIR_DOWN  = 2'b01,
    DIR_RIGHT = 2'b10,
    DIR_LEFT  = 2'b11
  } dir_e;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_SHL = 2'b11
  } op_e;

  typedef enum logic {
    ST_STEM = 1'b0,
    ST_DIFF = 1'b1
  } cell_st_e;

endpackage

// File: rtl/spare_diff_unit.sv
module spare_diff_unit
  import spare_cell_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             diff_req_i,
  input  logic [DIR_W-1:0] dir_i,
  output logic             active_o,
  output dir_e             dir_o,
  output logic             clr_o
);

  cell_st_e st_q, st_d;
  dir_e     dir_q, dir_d;
  logic     clr_q, clr_d;
  logic     take;

  // next state: the request is honoured once, from the dormant state only
  always_comb begin
    take  = (st_q == ST_STEM) && diff_req_i;
    st_d  = st_q;
    dir_d = dir_q;
    clr_d = 1'b0;
    if (take) begin
      st_d  = ST_DIFF;
      dir_d = dir_e'(dir_i);
      clr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_STEM;
      dir_q <= DIR_UP;
      clr_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      clr_q <= clr_d;
      if (take) begin
        dir_q <= dir_d;
      end
    end
  end

  assign active_o = (st_q == ST_DIFF);
  assign dir_o    = dir_q;
  assign clr_o    = clr_q;

endmodule

// File: rtl/spare_port_mux.sv
module spare_port_mux
  import spare_cell_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  dir_e                     sel_i,
  input  logic [NB_N-1:0]          valid_i,
  input  logic [NB_N*OP_W-1:0]     op_i,
  input  logic [NB_N*DATA_W-1:0]   a_i,
  input  logic [NB_N*DATA_W-1:0]   b_i,
  output logic                     valid_o,
  output op_e                      op_o,
  output logic [DATA_W-1:0]        a_o,
  output logic [DATA_W-1:0]        b_o
);

  logic [NB_N-1:0]                  hit;
  logic [NB_N-1:0][DATA_W-1:0]      a_m;
  logic [NB_N-1:0][DATA_W-1:0]      b_m;
  logic [NB_N-1:0][OP_W-1:0]        op_m;
  logic [OP_W-1:0]                  op_acc;

  // one-hot decode of the latched direction, then AND-OR selection
  for (genvar k = 0; k < NB_N; k++) begin : g_port
    assign hit[k]  = (sel_i == dir_e'(DIR_W'(k)));
    assign a_m[k]  = hit[k] ? a_i[k*DATA_W +: DATA_W] : '0;
    assign b_m[k]  = hit[k] ? b_i[k*DATA_W +: DATA_W] : '0;
    assign op_m[k] = hit[k] ? op_i[k*OP_W +: OP_W]    : '0;
  end

  always_comb begin
    valid_o = 1'b0;
    a_o     = '0;
    b_o     = '0;
    op_acc  = '0;
    for (int k = 0; k < NB_N; k++) begin
      valid_o = valid_o | (valid_i[k] & hit[k]);
      a_o     = a_o | a_m[k];
      b_o     = b_o | b_m[k];
      op_acc  = op_acc | op_m[k];
    end
    op_o = op_e'(op_acc);
  end

endmodule

// File: rtl/spare_alu_core.sv
module spare_alu_core
  import spare_cell_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_e                 op_i,
  input  logic [DATA_W-1:0]   a_i,
  input  logic [DATA_W-1:0]   b_i,
  output logic [2*DATA_W-1:0] res_o
);

  localparam int unsigned RES_W = 2 * DATA_W;
  localparam int unsigned SH_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam int unsigned PAD_W = RES_W - DATA_W - 1;

  logic [RES_W-1:0]  ext_a;
  logic [RES_W-1:0]  ext_b;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] diff;
  logic [SH_W-1:0]   shamt;

  always_comb begin
    ext_a = {{DATA_W{1'b0}}, a_i};
    ext_b = {{DATA_W{1'b0}}, b_i};
    sum   = {1'b0, a_i} + {1'b0, b_i};
    diff  = a_i - b_i;
    shamt = b_i[SH_W-1:0];
    unique case (op_i)
      OP_ADD:  res_o = {{PAD_W{1'b0}}, sum};
      OP_SUB:  res_o = {{DATA_W{1'b0}}, diff};
      OP_MUL:  res_o = ext_a * ext_b;
      OP_SHL:  res_o = ext_a << shamt;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/spare_alu_cell.sv
module spare_alu_cell
  import spare_cell_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     diff_req_i,
  input  logic [1:0]               dir_i,
  output logic                     diff_clr_o,
  output logic                     active_o,
  input  logic [3:0]               nb_valid_i,
  input  logic [7:0]               nb_op_i,
  input  logic [4*DATA_W-1:0]      nb_a_i,
  input  logic [4*DATA_W-1:0]      nb_b_i,
  output logic                     res_valid_o,
  output logic [2*DATA_W-1:0]      res_o
);

  localparam int unsigned RES_W = 2 * DATA_W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  dir_e              dir_q;
  logic              active;
  logic              sel_valid;
  op_e               sel_op;
  logic [DATA_W-1:0] sel_a;
  logic [DATA_W-1:0] sel_b;
  logic [RES_W-1:0]  alu_res;

  spare_diff_unit u_diff (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .diff_req_i (diff_req_i),
    .dir_i      (dir_i),
    .active_o   (active),
    .dir_o      (dir_q),
    .clr_o      (diff_clr_o)
  );

  spare_port_mux #(.DATA_W(DATA_W)) u_mux (
    .sel_i   (dir_q),
    .valid_i (nb_valid_i),
    .op_i    (nb_op_i),
    .a_i     (nb_a_i),
    .b_i     (nb_b_i),
    .valid_o (sel_valid),
    .op_o    (sel_op),
    .a_o     (sel_a),
    .b_o     (sel_b)
  );

  spare_alu_core #(.DATA_W(DATA_W)) u_alu (
    .op_i  (sel_op),
    .a_i   (sel_a),
    .b_i   (sel_b),
    .res_o (alu_res)
  );

  logic             res_vld_q, res_vld_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             res_en;

  always_comb begin
    res_en    = active && sel_valid;
    res_vld_d = res_en;
    res_d     = alu_res;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_vld_q <= 1'b0;
      res_q     <= '0;
    end else begin
      res_vld_q <= res_vld_d;
      if (res_en) begin
        res_q <= res_d;
      end
    end
  end

  assign active_o    = active;
  assign res_valid_o = res_vld_q;
  assign res_o       = res_q;

endmodule

// File: rtl/spare_alu_cell_chk.sv
module spare_alu_cell_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                diff_req_i,
  input logic                diff_clr_o,
  input logic                active_o,
  input logic [1:0]          dir_q,
  input logic                sel_valid,
  input logic                res_valid_o,
  input logic [2*DATA_W-1:0] res_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_o |-> (!res_valid_o && (res_o == '0) && !diff_clr_o));

  // R2
  active_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> active_o);

  // R3
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff_clr_o |=> !diff_clr_o);

  // R3
  clr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    diff_clr_o |-> (active_o && $past(diff_req_i) && !$past(active_o)));

  // R7
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_o |=> $stable(dir_q));

  // R5
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && sel_valid) |=> res_valid_o);

  // R6
  no_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(active_o && sel_valid) |=> !res_valid_o);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && !sel_valid) |=> $stable(res_o));

endmodule

bind spare_alu_cell spare_alu_cell_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .diff_req_i  (diff_req_i),
  .diff_clr_o  (diff_clr_o),
  .active_o    (active_o),
  .dir_q       (dir_q),
  .sel_valid   (sel_valid),
  .res_valid_o (res_valid_o),
  .res_o       (res_o)
);

// File: tb/spare_alu_cell_tb.sv
`timescale 1ns/1ps
module spare_alu_cell_tb;

  localparam int W = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          diff_req;
  logic [1:0]    dir;
  logic          diff_clr;
  logic          active;
  logic [3:0]    nb_valid;
  logic [7:0]    nb_op;
  logic [4*W-1:0] nb_a;
  logic [4*W-1:0] nb_b;
  logic          res_valid;
  logic [2*W-1:0] res;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spare_alu_cell #(.DATA_W(W)) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .diff_req_i  (diff_req),
    .dir_i       (dir),
    .diff_clr_o  (diff_clr),
    .active_o    (active),
    .nb_valid_i  (nb_valid),
    .nb_op_i     (nb_op),
    .nb_a_i      (nb_a),
    .nb_b_i      (nb_b),
    .res_valid_o (res_valid),
    .res_o       (res)
  );

  // {op, a, b, expected}
  localparam logic [33:0] VEC [8] = '{
    {2'b00, 8'h12, 8'h34, 16'h0046},
    {2'b00, 8'hFF, 8'h01, 16'h0100},
    {2'b01, 8'h50, 8'h20, 16'h0030},
    {2'b01, 8'h05, 8'h07, 16'h00FE},
    {2'b10, 8'h0F, 8'h11, 16'h00FF},
    {2'b10, 8'hFF, 8'hFF, 16'hFE01},
    {2'b11, 8'h81, 8'h03, 16'h0408},
    {2'b11, 8'h01, 8'h0F, 16'h0080}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every port busy with ADD F0+k: results 0xF0..0xF3 never match a vector
  task automatic load_noise();
    nb_valid = 4'hF;
    for (int k = 0; k < 4; k++) begin
      nb_op[2*k +: 2] = 2'b00;
      nb_a[k*W +: W]  = 8'hF0;
      nb_b[k*W +: W]  = W'(k);
    end
  endtask

  task automatic set_port(input int k, input logic v, input logic [1:0] op,
                          input logic [W-1:0] a, input logic [W-1:0] b);
    nb_valid[k]      = v;
    nb_op[2*k +: 2]  = op;
    nb_a[k*W +: W]   = a;
    nb_b[k*W +: W]   = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    diff_req = 1'b0;
    dir      = 2'b00;
    nb_valid = '0; nb_op = '0; nb_a = '0; nb_b = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R5 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; diff_req = 1'b0; dir = 2'b00;
    nb_valid = '0; nb_op = '0; nb_a = '0; nb_b = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", 32'(res_valid), 0);
    check("R1 reset result", 32'(res), 0);
    check("R1 reset active", 32'(active), 0);
    check("R1 reset clear", 32'(diff_clr), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 dormant cell ignores traffic
    load_noise();
    @(negedge clk);
    @(negedge clk);
    check("R1 dormant valid", 32'(res_valid), 0);
    check("R1 dormant result", 32'(res), 0);

    // R2 / R3 differentiate toward the right neighbour
    diff_req = 1'b1;
    dir      = 2'b10;
    @(negedge clk);
    check("R2 active after accept", 32'(active), 1);
    check("R3 clear pulse", 32'(diff_clr), 1);
    diff_req = 1'b0;
    @(negedge clk);
    check("R3 clear single cycle", 32'(diff_clr), 0);

    // R4 / R5 vector table on port 2, back to back
    for (int i = 0; i < 8; i++) begin
      load_noise();
      set_port(2, 1'b1, VEC[i][33:32], VEC[i][31:24], VEC[i][23:16]);
      @(negedge clk);
      check("R5 valid", 32'(res_valid), 1);
      check("R4 result", 32'(res), 32'(VEC[i][15:0]));
    end

    // R6 selected port idle, others busy: no valid, result held
    load_noise();
    nb_valid[2] = 1'b0;
    @(negedge clk);
    check("R6 no valid", 32'(res_valid), 0);
    check("R6 hold", 32'(res), 32'h0080);
    @(negedge clk);
    check("R6 hold second cycle", 32'(res), 32'h0080);

    // R7 new request and direction are ignored
    diff_req = 1'b1;
    dir      = 2'b00;
    load_noise();
    set_port(0, 1'b1, 2'b00, 8'h01, 8'h01);
    set_port(2, 1'b1, 2'b00, 8'h05, 8'h05);
    @(negedge clk);
    check("R7 result from right port", 32'(res), 32'h000A);
    check("R7 no clear", 32'(diff_clr), 0);
    @(negedge clk);
    check("R7 no clear later", 32'(diff_clr), 0);
    check("R7 still right port", 32'(res), 32'h000A);
    diff_req = 1'b0;

    // R8 reset then differentiate toward every direction
    for (int d = 0; d < 4; d++) begin
      do_reset();
      check("R8 dormant after reset", 32'(active), 0);
      check("R8 result cleared", 32'(res), 0);
      diff_req = 1'b1;
      dir      = 2'(d);
      @(negedge clk);
      check("R8 clear pulse", 32'(diff_clr), 1);
      diff_req = 1'b0;
      load_noise();
      set_port(d, 1'b1, 2'b00, 8'(8'h10 * d + 1), 8'h02);
      @(negedge clk);
      check("R8 valid", 32'(res_valid), 1);
      check("R8 selected port", 32'(res), 32'(16 * d + 3));
    end

    finish_run();
  end

endmodule